// File: doc/BRIEF.md
# DRAM Address Field Mapper

This block splits a flat byte address into the chip-select, row, bank and column coordinates that a DRAM controller needs. The split depends on a geometry configuration: the number of column, row and bank address bits, an encoded chip-select count, the interface width, and a selector for the order of the fields in the address.

The block also reports the total addressable memory size for the configured geometry. It raises an out-of-range flag whenever the presented address lies at or above that size. ECC lanes are not addressable, so the size and the byte-lane offset count only the data width.

Every output is registered. The decoded coordinates, the flag and the size for an address presented in one cycle appear after the next rising clock edge. Command scheduling and DRAM timing belong to other blocks.

Top module: `dram_addr_mapper`

## Requirements
- R1: With order code 0, the address is split from least to most significant as byte-lane bits, then `cfg_col_bits_i` column bits, then `cfg_bank_bits_i` bank bits, then the row bits, then the chip-select bit. The number of byte-lane bits is log2 of the interface width in bytes.
- R2: With order code 2, the address is split from least to most significant as byte-lane bits, column, bank, chip-select bit, then row. The row therefore sits above the chip select.
- R3: Order codes 1 and 3 decode exactly as order code 0.
- R4: `cfg_cs_sel_i` holds the chip-select count minus one, so 0 means one chip and 1 means two chips. With one chip, `chip_o` is always 0 and no address bit is given to the chip field.
- R5: `mem_size_o` equals 2^(row+bank+column bits) × (cfg_cs_sel_i+1) × (interface width / 8).
- R6: The interface width codes on `cfg_width_i` are:
  - 0 = 8 bits
  - 1 = 16 bits
  - 2 = 32 bits
  - 3 = 16 bits plus ECC, counted as 16 bits
  - 4 = 32 bits plus ECC, counted as 32 bits
  - codes 5 to 7 count as 8 bits

  The same counted width sets both the byte-lane bits and the size.
- R7: A configured row count above 31 is not used. The parameter `DEFAULT_ROW_BITS` (default 14) replaces it in both the decode and the size.
- R8: `out_of_range_o` is 1 exactly when the address is greater than or equal to the computed size.
- R9: All outputs are registered with one cycle of latency. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Flat byte address |
| cfg_col_bits_i | input | 4 | Column address bit count |
| cfg_row_bits_i | input | 6 | Row address bit count (values above 31 are replaced) |
| cfg_bank_bits_i | input | 3 | Bank address bit count |
| cfg_cs_sel_i | input | 1 | Chip-select count minus one |
| cfg_order_i | input | 2 | Field order selector (0 or 2; 1 and 3 act as 0) |
| cfg_width_i | input | 3 | Interface width code |
| chip_o | output | 1 | Decoded chip select |
| row_o | output | 31 | Decoded row |
| bank_o | output | 7 | Decoded bank |
| col_o | output | 15 | Decoded column |
| out_of_range_o | output | 1 | Address at or beyond the memory size |
| mem_size_o | output | SIZE_W | Addressable memory size in bytes |

## Verification
The hardest cases to reach from the ports are those where the replaced row count and the ECC width codes change the field boundaries in ways a simple address sweep would miss.

The bench builds each stimulus address from chosen field values, using the layout the requirements describe. It then expects those same values back, so every boundary between fields is probed with distinct bit patterns. Row counts above 31 and the ECC width codes are driven explicitly. The size boundary is probed with the last in-range address and the first address past it.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    // Configuration field widths (register layout of the geometry word)
    localparam int COL_CFG_W  = 4;
    localparam int ROW_CFG_W  = 6;
    localparam int BANK_CFG_W = 3;
    localparam int ROW_LIMIT  = 31;
    localparam int SHIFT_W    = 8;

    // Widest decoded fields
    localparam int COL_OUT_W  = (1 << COL_CFG_W) - 1;
    localparam int ROW_OUT_W  = ROW_LIMIT;
    localparam int BANK_OUT_W = (1 << BANK_CFG_W) - 1;

    // Width codes
    localparam logic [2:0] WCODE_X8      = 3'd0;
    localparam logic [2:0] WCODE_X16     = 3'd1;
    localparam logic [2:0] WCODE_X32     = 3'd2;
    localparam logic [2:0] WCODE_X16_ECC = 3'd3;
    localparam logic [2:0] WCODE_X32_ECC = 3'd4;

    typedef enum logic {
        LAYOUT_CHIP_TOP = 1'b0,
        LAYOUT_ROW_TOP  = 1'b1
    } layout_e;

    typedef struct packed {
        layout_e                layout;
        logic [COL_CFG_W-1:0]   col_bits;
        logic [ROW_CFG_W-1:0]   row_bits;
        logic [BANK_CFG_W-1:0]  bank_bits;
        logic                   cs_bits;
        logic [1:0]             lane_bits;
    } geom_t;

    typedef struct packed {
        logic                   chip;
        logic [ROW_OUT_W-1:0]   row;
        logic [BANK_OUT_W-1:0]  bank;
        logic [COL_OUT_W-1:0]   col;
    } dram_loc_t;

    // Only code 2 moves the row above the chip select
    function automatic layout_e map_order(input logic [1:0] code);
        return (code == 2'd2) ? LAYOUT_ROW_TOP : LAYOUT_CHIP_TOP;
    endfunction

    // log2 of data bytes per beat; ECC lanes are excluded
    function automatic logic [1:0] lane_bits_of(input logic [2:0] code);
        case (code)
            WCODE_X16, WCODE_X16_ECC: return 2'd1;
            WCODE_X32, WCODE_X32_ECC: return 2'd2;
            default:                  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dmap_geom_norm.sv
module dmap_geom_norm
    import dmap_pkg::*;
#(
    parameter int DEFAULT_ROW_BITS = 14
) (
    input  logic [COL_CFG_W-1:0]  col_bits_i,
    input  logic [ROW_CFG_W-1:0]  row_bits_i,
    input  logic [BANK_CFG_W-1:0] bank_bits_i,
    input  logic                  cs_sel_i,
    input  logic [1:0]            order_i,
    input  logic [2:0]            width_i,
    output geom_t                 geom_o
);
    localparam logic [ROW_CFG_W-1:0] ROW_FALLBACK = ROW_CFG_W'(DEFAULT_ROW_BITS);

    always_comb begin
        geom_o.layout    = map_order(order_i);
        geom_o.col_bits  = col_bits_i;
        geom_o.row_bits  = (row_bits_i > ROW_CFG_W'(ROW_LIMIT)) ? ROW_FALLBACK : row_bits_i;
        geom_o.bank_bits = bank_bits_i;
        geom_o.cs_bits   = cs_sel_i;
        geom_o.lane_bits = lane_bits_of(width_i);
    end

endmodule

// File: rtl/dmap_size_calc.sv
module dmap_size_calc
    import dmap_pkg::*;
#(
    parameter int SIZE_W = 64
) (
    input  logic [COL_CFG_W-1:0]  col_bits_i,
    input  logic [ROW_CFG_W-1:0]  row_bits_i,
    input  logic [BANK_CFG_W-1:0] bank_bits_i,
    input  logic                  cs_bits_i,
    input  logic [1:0]            lane_bits_i,
    output logic [SIZE_W-1:0]     size_o
);
    logic [SHIFT_W-1:0] total_shift;

    // Chip count is 1 or 2 and bytes are 1, 2 or 4: all powers of two
    always_comb begin
        total_shift = SHIFT_W'(col_bits_i) + SHIFT_W'(row_bits_i) + SHIFT_W'(bank_bits_i)
                    + SHIFT_W'(cs_bits_i) + SHIFT_W'(lane_bits_i);
        size_o = SIZE_W'(1) << total_shift;
    end

endmodule

// File: rtl/dmap_field_split.sv
module dmap_field_split
    import dmap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  geom_t             geom_i,
    output dram_loc_t         loc_o
);
    function automatic logic [ADDR_W-1:0] low_ones(input logic [SHIFT_W-1:0] n);
        return (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction

    logic [ADDR_W-1:0] above_lane;
    logic [ADDR_W-1:0] above_col;
    logic [ADDR_W-1:0] above_bank;
    logic [ADDR_W-1:0] above_row;
    logic [ADDR_W-1:0] above_cs;

    always_comb begin
        above_lane = addr_i >> geom_i.lane_bits;
        above_col  = above_lane >> geom_i.col_bits;
        above_bank = above_col >> geom_i.bank_bits;
        above_row  = above_bank >> geom_i.row_bits;
        above_cs   = above_bank >> geom_i.cs_bits;

        loc_o.col  = COL_OUT_W'(above_lane & low_ones(SHIFT_W'(geom_i.col_bits)));
        loc_o.bank = BANK_OUT_W'(above_col & low_ones(SHIFT_W'(geom_i.bank_bits)));

        if (geom_i.layout == LAYOUT_ROW_TOP) begin
            loc_o.chip = above_bank[0] & geom_i.cs_bits;
            loc_o.row  = ROW_OUT_W'(above_cs & low_ones(SHIFT_W'(geom_i.row_bits)));
        end else begin
            loc_o.chip = above_row[0] & geom_i.cs_bits;
            loc_o.row  = ROW_OUT_W'(above_bank & low_ones(SHIFT_W'(geom_i.row_bits)));
        end
    end

endmodule

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper
    import dmap_pkg::*;
#(
    parameter int ADDR_W           = 32,
    parameter int SIZE_W           = 64,
    parameter int DEFAULT_ROW_BITS = 14
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [COL_CFG_W-1:0]   cfg_col_bits_i,
    input  logic [ROW_CFG_W-1:0]   cfg_row_bits_i,
    input  logic [BANK_CFG_W-1:0]  cfg_bank_bits_i,
    input  logic                   cfg_cs_sel_i,
    input  logic [1:0]             cfg_order_i,
    input  logic [2:0]             cfg_width_i,
    output logic                   chip_o,
    output logic [ROW_OUT_W-1:0]   row_o,
    output logic [BANK_OUT_W-1:0]  bank_o,
    output logic [COL_OUT_W-1:0]   col_o,
    output logic                   out_of_range_o,
    output logic [SIZE_W-1:0]      mem_size_o
);
    geom_t              geom;
    dram_loc_t          loc_d;
    logic [SIZE_W-1:0]  size_d;
    logic               beyond_d;

    dmap_geom_norm #(.DEFAULT_ROW_BITS(DEFAULT_ROW_BITS)) u_norm (
        .col_bits_i  (cfg_col_bits_i),
        .row_bits_i  (cfg_row_bits_i),
        .bank_bits_i (cfg_bank_bits_i),
        .cs_sel_i    (cfg_cs_sel_i),
        .order_i     (cfg_order_i),
        .width_i     (cfg_width_i),
        .geom_o      (geom)
    );

    dmap_size_calc #(.SIZE_W(SIZE_W)) u_size (
        .col_bits_i  (geom.col_bits),
        .row_bits_i  (geom.row_bits),
        .bank_bits_i (geom.bank_bits),
        .cs_bits_i   (geom.cs_bits),
        .lane_bits_i (geom.lane_bits),
        .size_o      (size_d)
    );

    dmap_field_split #(.ADDR_W(ADDR_W)) u_split (
        .addr_i (addr_i),
        .geom_i (geom),
        .loc_o  (loc_d)
    );

    assign beyond_d = (SIZE_W'(addr_i) >= size_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_o         <= 1'b0;
            row_o          <= '0;
            bank_o         <= '0;
            col_o          <= '0;
            out_of_range_o <= 1'b0;
            mem_size_o     <= '0;
        end else begin
            chip_o         <= loc_d.chip;
            row_o          <= loc_d.row;
            bank_o         <= loc_d.bank;
            col_o          <= loc_d.col;
            out_of_range_o <= beyond_d;
            mem_size_o     <= size_d;
        end
    end

    AST_ONE_CHIP_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cfg_cs_sel_i == 1'b0) |=> (chip_o == 1'b0)); // R4

    AST_COL_FITS_COUNT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((col_o >> $past(cfg_col_bits_i)) == '0)); // R1

    AST_SIZE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mem_size_o != '0)); // R5

    AST_ZERO_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (addr_i == '0) |=> !out_of_range_o); // R8

    AST_ROW_FALLBACK_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (cfg_row_bits_i > ROW_CFG_W'(ROW_LIMIT)) |=> ((row_o >> DEFAULT_ROW_BITS) == '0)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (mem_size_o == '0 && !out_of_range_o && row_o == '0 && col_o == '0)); // R9

endmodule

// File: tb/tb_dram_addr_mapper.sv
`timescale 1ns/1ps
module tb_dram_addr_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [3:0]  cbits = '0;
    logic [5:0]  rbits = '0;
    logic [2:0]  bbits = '0;
    logic        csel = 1'b0;
    logic [1:0]  order = '0;
    logic [2:0]  wcode = '0;
    logic        chip;
    logic [30:0] row;
    logic [6:0]  bank;
    logic [14:0] col;
    logic        oor;
    logic [63:0] msize;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    dram_addr_mapper dut (
        .clk(clk), .rst(rst), .addr_i(addr),
        .cfg_col_bits_i(cbits), .cfg_row_bits_i(rbits), .cfg_bank_bits_i(bbits),
        .cfg_cs_sel_i(csel), .cfg_order_i(order), .cfg_width_i(wcode),
        .chip_o(chip), .row_o(row), .bank_o(bank), .col_o(col),
        .out_of_range_o(oor), .mem_size_o(msize)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Bench-side model of the requirements
    function automatic int lane_of(input logic [2:0] w);   // R6
        if (w == 3'd1 || w == 3'd3) return 1;
        if (w == 3'd2 || w == 3'd4) return 2;
        return 0;
    endfunction

    function automatic int eff_rows(input int r);          // R7
        return (r > 31) ? 14 : r;
    endfunction

    function automatic logic [63:0] exp_size(input int c, input int r, input int b, input int cs, input logic [2:0] w);
        return (64'd1 << (c + eff_rows(r) + b)) * 64'(cs + 1) * 64'(1 << lane_of(w));   // R5
    endfunction

    function automatic logic [63:0] build(input logic [1:0] ord, input int c, input int r, input int b, input int cs,
                                          input logic [2:0] w, input longint ch, input longint rw,
                                          input longint bk, input longint cl);
        longint v;
        int ln = lane_of(w);
        int er = eff_rows(r);
        if (ord == 2'd2) begin
            v = rw; v = (v << cs) | ch;
        end else begin
            v = ch; v = (v << er) | rw;
        end
        v = (v << b) | bk;
        v = (v << c) | cl;
        v = (v << ln) | ((ln > 0) ? 64'd1 : 64'd0);
        return 64'(v);
    endfunction

    task automatic apply(input logic [31:0] a, input logic [1:0] ord, input int c, input int r,
                         input int b, input int cs, input logic [2:0] w);
        @(negedge clk);
        addr = a; order = ord; cbits = 4'(c); rbits = 6'(r); bbits = 3'(b); csel = cs[0]; wcode = w;
        @(negedge clk);
    endtask

    task automatic run_decode(input string tag, input logic [1:0] ord, input int c, input int r, input int b,
                              input int cs, input logic [2:0] w, input longint ch, input longint rw,
                              input longint bk, input longint cl);
        logic [63:0] a = build(ord, c, r, b, cs, w, ch, rw, bk, cl);
        apply(a[31:0], ord, c, r, b, cs, w);
        chk(tag, "chip", 64'(chip), 64'(ch));
        chk(tag, "row",  64'(row),  64'(rw));
        chk(tag, "bank", 64'(bank), 64'(bk));
        chk(tag, "col",  64'(col),  64'(cl));
        chk(tag, "out_of_range", 64'(oor), 64'd0);
        chk(tag, "size", msize, exp_size(c, r, b, cs, w));
    endtask

    task automatic t_reset;   // R9
        @(negedge clk);
        chk("R9", "chip", 64'(chip), 0);
        chk("R9", "row",  64'(row),  0);
        chk("R9", "col",  64'(col),  0);
        chk("R9", "out_of_range", 64'(oor), 0);
        chk("R9", "size", msize, 0);
    endtask

    task automatic t_order_chip_top;   // R1
        run_decode("R1", 2'd0, 10, 13, 3, 1, 3'd2, 1, 64'h0ABC, 5, 64'h155);
        run_decode("R1", 2'd0, 9, 12, 2, 1, 3'd1, 0, 64'h0F0F, 2, 64'h0AA);
    endtask

    task automatic t_order_row_top;    // R2
        run_decode("R2", 2'd2, 10, 13, 3, 1, 3'd2, 1, 64'h0ABC, 5, 64'h155);
        run_decode("R2", 2'd2, 8, 14, 3, 1, 3'd0, 0, 64'h2345, 6, 64'h3C);
    endtask

    task automatic t_order_other;      // R3
        run_decode("R3", 2'd1, 10, 13, 3, 1, 3'd2, 1, 64'h1234, 3, 64'h2AB);
        run_decode("R3", 2'd3, 10, 13, 3, 1, 3'd2, 1, 64'h1234, 3, 64'h2AB);
    endtask

    task automatic t_single_chip;      // R4
        run_decode("R4", 2'd0, 10, 14, 3, 0, 3'd2, 0, 64'h3FFF, 7, 64'h3FF);
        // Bit just above the row would be the chip bit with two chips
        apply(32'h1 << (2 + 10 + 3 + 14), 2'd0, 10, 14, 3, 0, 3'd2);
        chk("R4", "chip one-chip", 64'(chip), 0);
        chk("R4", "oor above one-chip", 64'(oor), 1);
        run_decode("R4", 2'd2, 10, 14, 3, 0, 3'd2, 0, 64'h2AAA, 1, 64'h011);
    endtask

    task automatic t_widths;           // R6
        run_decode("R6", 2'd0, 10, 13, 3, 1, 3'd3, 1, 64'h0555, 4, 64'h321);
        run_decode("R6", 2'd0, 10, 13, 3, 1, 3'd4, 1, 64'h0555, 4, 64'h321);
        run_decode("R6", 2'd0, 10, 13, 3, 1, 3'd6, 1, 64'h0555, 4, 64'h321);
    endtask

    task automatic t_row_fallback;     // R7
        run_decode("R7", 2'd0, 10, 40, 3, 1, 3'd2, 1, 64'h2ABC, 6, 64'h0F0);
        run_decode("R7", 2'd2, 10, 63, 3, 1, 3'd2, 1, 64'h1ABC, 2, 64'h0F1);
    endtask

    task automatic t_boundary;         // R8
        logic [63:0] s = exp_size(10, 13, 3, 1, 3'd2);
        apply(32'(s - 1), 2'd0, 10, 13, 3, 1, 3'd2);
        chk("R8", "last in range", 64'(oor), 0);
        apply(32'(s), 2'd0, 10, 13, 3, 1, 3'd2);
        chk("R8", "first beyond", 64'(oor), 1);
        apply(32'hFFFF_FFFF, 2'd0, 8, 12, 2, 0, 3'd0);
        chk("R8", "top address small part", 64'(oor), 1);
    endtask

    task automatic t_big_size;         // R5
        apply(32'hFFFF_FFFF, 2'd0, 12, 31, 3, 1, 3'd2);
        chk("R5", "size large", msize, 64'd1 << 49);
        chk("R5", "no oor in large", 64'(oor), 0);
        apply(32'h0, 2'd2, 1, 1, 0, 0, 3'd0);
        chk("R5", "size tiny", msize, 64'd4);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk) rst = 1'b0;
        t_order_chip_top();
        t_order_row_top();
        t_order_other();
        t_single_chip();
        t_widths();
        t_row_fallback();
        t_boundary();
        t_big_size();
        done = 1;
        finish_run();
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule